// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog counter that runs from the core clock through a power-of-two prescaler. Firmware must restart it from time to time with a clear strobe. If firmware fails to do so, the counter wraps and the block raises a one-cycle reset request. The block also keeps two status flags. `no_timeout` reads 0 after a watchdog expiry. `no_powerdown` reads 0 after a sleep command. Startup code reads these flags to learn why the device came out of reset.

The clear strobe restarts both the counter and the prescaler and sets both flags. The sleep strobe also restarts the count, sets `no_timeout` and drops `no_powerdown`. When the enable input is low, the count stays at zero and no request is raised. The flags still respond to the clear and sleep strobes while the block is disabled.

Top module: `wdt_prescaled`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `wdt_reset` is 0 and both `no_timeout` and `no_powerdown` are 1.
- R2: The prescaler divides by 2^`ratio_sel`, which gives 1 to 128. The 8-bit counter advances once per prescaler wrap. After a clear, with enable held high and no other strobe, `wdt_reset` is first high exactly 256·2^`ratio_sel` clock edges after the clearing edge.
- R3: An expiry makes `wdt_reset` high for exactly one cycle. `no_timeout` reads 0 from that same cycle onward.
- R4: A clear strobe zeroes the counter and the prescaler and sets both flags to 1. The next expiry comes a full period after the clearing edge.
- R5: A clear strobe sampled on the edge where the counter would wrap stops the request: `wdt_reset` stays 0 after that edge.
- R6: A sleep strobe sets `no_powerdown` to 0 and `no_timeout` to 1, and restarts the counter and prescaler from zero. An expiry does not change `no_powerdown`.
- R7: When clear and sleep are sampled on the same edge, the clear wins and both flags are 1 afterwards.
- R8: While `wdt_en` is low, the counter and prescaler are held at zero and `wdt_reset` stays 0. Once enabled again, a full period runs before an expiry. The flags still respond to the clear and sleep strobes while disabled.
- R9: If `ratio_sel` changes so that the prescaler's present value is at or above the new terminal value, the prescaler wraps on the next enabled edge and the counter advances.
- R10: After an expiry the counter keeps running from zero. The next request follows one full period later unless a strobe intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdt_en | input | 1 | Enables counting |
| clr_wdt | input | 1 | Clear strobe from the core |
| sleep_cmd | input | 1 | Sleep strobe from the core |
| ratio_sel | input | 3 | Prescaler exponent n; ratio is 2^n |
| wdt_reset | output | 1 | One-cycle reset request on expiry |
| no_timeout | output | 1 | 0 after a watchdog expiry |
| no_powerdown | output | 1 | 0 after a sleep command |

## Verification
The hardest case to reach is a strobe that lands on the exact edge where the counter would wrap. The ports do not show the counter, so that edge can only be found by counting cycles from a known restart. The directed part issues a clear, counts exactly 255 edges at ratio 1, and drives the clear again on the 256th edge. A ratio change in the middle of a period is reached the same way: the bench counts partway into a slow ratio and then switches to a faster one. The random part uses small ratios, so that many expiries occur among rare strobes and enable drops.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_en,
  input  logic             clr_wdt,
  input  logic             sleep_cmd,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             wdt_reset,
  output logic             no_timeout,
  output logic             no_powerdown
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;
  logic             tick, wrap;

  assign span = (PRE_W+1)'(1) << ratio_sel;
  assign last = PRE_W'(span - (PRE_W+1)'(1));
  assign tick = wdt_en && (pre >= last);
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre          <= '0;
      cnt          <= '0;
      wdt_reset    <= 1'b0;
      no_timeout   <= 1'b1;
      no_powerdown <= 1'b1;
    end else begin
      wdt_reset <= 1'b0;
      if (clr_wdt) begin
        pre          <= '0;
        cnt          <= '0;
        no_timeout   <= 1'b1;
        no_powerdown <= 1'b1;
      end else if (sleep_cmd) begin
        pre          <= '0;
        cnt          <= '0;
        no_timeout   <= 1'b1;
        no_powerdown <= 1'b0;
      end else if (!wdt_en) begin
        pre <= '0;
        cnt <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
        if (wrap) begin
          wdt_reset  <= 1'b1;
          no_timeout <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_prescaled_props.sv
module wdt_prescaled_props (
  input logic clk,
  input logic rst_n,
  input logic wdt_en,
  input logic clr_wdt,
  input logic sleep_cmd,
  input logic wdt_reset,
  input logic no_timeout,
  input logic no_powerdown
);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  p_pulse_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> !no_timeout);
  p_clear_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> (no_timeout && no_powerdown));
  p_clear_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> !wdt_reset);
  p_sleep_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_cmd && !clr_wdt) |=> (!no_powerdown && no_timeout));
  p_pd_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_cmd && !clr_wdt) |=> $stable(no_powerdown));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_reset);
endmodule

bind wdt_prescaled wdt_prescaled_props u_props (
  .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .clr_wdt(clr_wdt),
  .sleep_cmd(sleep_cmd), .wdt_reset(wdt_reset),
  .no_timeout(no_timeout), .no_powerdown(no_powerdown)
);

// File: tb/wdt_prescaled_test.sv
module wdt_prescaled_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wdt_en = 1'b0, clr_wdt = 1'b0, sleep_cmd = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic wdt_reset, no_timeout, no_powerdown;

  int vectors = 0, fails = 0, edges = 0;

  wdt_prescaled uut (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .clr_wdt(clr_wdt),
    .sleep_cmd(sleep_cmd), .ratio_sel(ratio_sel), .wdt_reset(wdt_reset),
    .no_timeout(no_timeout), .no_powerdown(no_powerdown)
  );

  always #2 clk = ~clk;

  // reference model built from the requirements
  int m_pre = 0, m_cnt = 0;
  logic m_rst = 1'b0, m_to = 1'b1, m_pd = 1'b1;

  function automatic int last_of(input int sel);
    return (1 << sel) - 1;
  endfunction

  function automatic int period_of(input int sel);
    return 256 << sel;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_rst <= 1'b0; m_to <= 1'b1; m_pd <= 1'b1;
    end else begin
      m_rst <= 1'b0;
      if (clr_wdt) begin
        m_pre <= 0; m_cnt <= 0; m_to <= 1'b1; m_pd <= 1'b1;
      end else if (sleep_cmd) begin
        m_pre <= 0; m_cnt <= 0; m_to <= 1'b1; m_pd <= 1'b0;
      end else if (!wdt_en) begin
        m_pre <= 0; m_cnt <= 0;
      end else if (m_pre >= last_of(int'(ratio_sel))) begin
        m_pre <= 0;
        m_cnt <= (m_cnt + 1) % 256;
        if (m_cnt == 255) begin m_rst <= 1'b1; m_to <= 1'b0; end
      end else begin
        m_pre <= m_pre + 1;
      end
    end
  end

  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d edges expected under 150000", edges);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_now();
    clr_wdt = 1'b1; cyc(); clr_wdt = 1'b0;
  endtask

  // counts edges until wdt_reset rises; caller has just passed the restart edge
  task automatic count_to_pulse(output int n);
    n = 0;
    do begin cyc(); n++; end while (!wdt_reset && n < 40000);
  endtask

  int n;

  initial begin
    void'($urandom(32'd20240611));
    cyc(); cyc();
    check("R1 reset wdt_reset", wdt_reset, 0);
    check("R1 reset no_timeout", no_timeout, 1);
    check("R1 reset no_powerdown", no_powerdown, 1);
    rst_n = 1'b1; cyc();
    check("R1 released wdt_reset", wdt_reset, 0);
    check("R1 released no_timeout", no_timeout, 1);
    check("R1 released no_powerdown", no_powerdown, 1);

    wdt_en = 1'b1; ratio_sel = 3'd0;
    clear_now(); count_to_pulse(n);
    check("R2 period ratio 1", n, period_of(0));
    check("R3 flag at pulse", no_timeout, 0);
    check("R6 pd untouched by expiry", no_powerdown, 1);
    cyc();
    check("R3 pulse one cycle", wdt_reset, 0);
    check("R3 flag stays low", no_timeout, 0);
    count_to_pulse(n);
    check("R10 second period", n + 1, period_of(0));

    ratio_sel = 3'd2;
    clear_now();
    check("R4 clear sets no_timeout", no_timeout, 1);
    check("R4 clear sets no_powerdown", no_powerdown, 1);
    count_to_pulse(n);
    check("R2 period ratio 4", n, period_of(2));

    ratio_sel = 3'd7;
    clear_now(); count_to_pulse(n);
    check("R2 period ratio 128", n, period_of(7));

    // clear on the wrap edge
    ratio_sel = 3'd0;
    clear_now();
    for (int i = 0; i < 255; i++) cyc();
    clr_wdt = 1'b1; cyc(); clr_wdt = 1'b0;
    check("R5 clear on wrap edge", wdt_reset, 0);
    check("R5 flag kept", no_timeout, 1);
    count_to_pulse(n);
    check("R4 full period after clear", n, period_of(0));

    sleep_cmd = 1'b1; cyc(); sleep_cmd = 1'b0;
    check("R6 sleep drops no_powerdown", no_powerdown, 0);
    check("R6 sleep sets no_timeout", no_timeout, 1);
    count_to_pulse(n);
    check("R6 restart after sleep", n, period_of(0));
    check("R6 pd held through expiry", no_powerdown, 0);

    clr_wdt = 1'b1; sleep_cmd = 1'b1; cyc(); clr_wdt = 1'b0; sleep_cmd = 1'b0;
    check("R7 clear wins no_powerdown", no_powerdown, 1);
    check("R7 clear wins no_timeout", no_timeout, 1);

    // disable holds
    clear_now();
    for (int i = 0; i < 200; i++) cyc();
    wdt_en = 1'b0;
    n = 0;
    for (int i = 0; i < 300; i++) begin cyc(); if (wdt_reset) n++; end
    check("R8 no pulse while disabled", n, 0);
    sleep_cmd = 1'b1; cyc(); sleep_cmd = 1'b0;
    check("R8 sleep while disabled", no_powerdown, 0);
    clear_now();
    check("R8 clear while disabled", no_powerdown, 1);
    wdt_en = 1'b1;
    count_to_pulse(n);
    check("R8 full period after enable", n, period_of(0));

    // ratio change mid-count
    ratio_sel = 3'd3;
    clear_now();
    for (int i = 0; i < 6; i++) cyc();
    ratio_sel = 3'd1;
    count_to_pulse(n);
    check("R9 wrap on ratio drop", n, 511);

    // random phase against the model
    for (int i = 0; i < 40000; i++) begin
      wdt_en    = ($urandom % 64) != 0;
      clr_wdt   = ($urandom % 3000) == 0;
      sleep_cmd = ($urandom % 3000) == 0;
      if (($urandom % 500) == 0) ratio_sel = 3'($urandom % 3);
      cyc();
      check("R2 random wdt_reset", wdt_reset, m_rst);
      check("R3 random no_timeout", no_timeout, m_to);
      check("R6 random no_powerdown", no_powerdown, m_pd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule